// File: doc/BRIEF.md
# Power-Gated Configuration Init Sequencer

After reset this block walks a constant table of (index, value) byte pairs and programs each pair into a host-side configuration space. It reaches that space through a small register port on a configuration bridge. The bridge itself lies outside the block; here it is any target that answers single-cycle reads and writes on the bus pins.

Each table entry is handled as a bracketed transaction:

- The sequencer first locks out the host and turns on the controller path. It waits for the bridge to become idle and then opens the target.
- It writes the index and waits for the write-busy flag to clear.
- It writes the value and waits for write-busy again.
- It then closes the bracket in reverse order.

Busy waits are bounded. Each poll is preceded by a fixed gap of clock cycles, and the number of polls has a limit. A host power-good input is sampled before every entry.

The walk ends at the table end or at the first entry that fails. At that point the block raises a one-cycle done pulse. A sticky error flag and the number of the failing entry remain readable until the next reset.

Top module: `cfgseq_init`

## Requirements
- R1: After reset release the table is walked from entry 0 upward. Each entry writes its index byte and then its value byte into the bridge. The default table holds nine pairs in this order: (0x07,0x06) (0x70,0x01) (0x30,0x01) (0x07,0x05) (0x70,0x0C) (0x30,0x01) (0x07,0x11) (0x70,0x00) (0x30,0x01). Index 0x07 selects a device, 0x70 sets that device's interrupt number, and 0x30 activates it.
- R2: Bridge register offsets on `bus_addr` are as follows. Offset 0 is the slot pointer: a value of 0 aims the next data write at the index slot, and 1 aims it at the value slot. Offset 1 is data. Offset 2 is the host lock, bits 1:0. Offset 4 is the target enable, bit 0. Offset 5 is control: bit 0 is path on, bit 1 is read request and bit 2 is write busy. Accesses are single-cycle, and read data is returned in the same cycle.
- R3: Before the index write the sequencer performs these steps in order:
  - It sets lock bits 1:0 and then control bit 0, each by read-modify-write.
  - It polls until control bits 1 and 2 both read 0.
  - It sets target enable bit 0.
  - It writes data only while all three are set.
- R4: If control bits 1 and 2 are still not clear after the last enable-phase poll, control bit 1 is cleared and the entry continues normally.
- R5: Every poll is preceded by a wait of POLL_GAP cycles, so back-to-back polls are POLL_GAP+2 cycles apart. At most POLL_LIMIT (10) polls are made. If a write-busy bit is still set on the last poll, the entry fails; if it reads clear on that poll, the entry succeeds.
- R6: After every entry that was started, whether it passed or failed, the sequencer clears target enable bit 0, then control bit 0, then lock bits 1:0.
- R7: An entry is started only if `host_pwr_ok` is high when the entry is due. If it is low, that entry is reported as failed and makes no bus access.
- R8: The walk stops at the first failing entry, and no later entry is touched.
- R9: `done` is a single-cycle pulse. It comes two cycles after the final unlock write; if the first entry was blocked by power, it comes without any bus access. No bus access follows it.
- R10: `err` and `fail_idx` hold the result until reset. A clean walk leaves `err` at 0 and `fail_idx` at 0.
- R11: While reset is held, `done`, `err` and `fail_idx` are 0 and no bus access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_pwr_ok | input | 1 | Host power good, sampled before each entry |
| bus_vld | output | 1 | Bridge access this cycle |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Bridge register offset |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, same cycle |
| done | output | 1 | Walk finished pulse |
| err | output | 1 | Sticky failure flag |
| fail_idx | output | 4 | Number of the failing entry |

## Verification
Polls are timed between the edges on which the bench sees consecutive control reads. With no other access in between, each such pair must be exactly POLL_GAP+2 cycles apart, and a series of k busy answers must yield exactly k such intervals. The done pulse is timed from the edge of the final unlock write and is expected two edges later. A power drop is applied through a bench counter that updates at the unlock edge, so the drop is in place for the very next entry check. Results, the configuration image and the final lock, enable and control bits are sampled on falling edges once the walk has settled.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   localparam int REG_AW = 3;

   // bridge register offsets (decoded by the bridge)
   localparam logic [REG_AW-1:0] OFS_PTR  = 3'd0;
   localparam logic [REG_AW-1:0] OFS_DAT  = 3'd1;
   localparam logic [REG_AW-1:0] OFS_LOCK = 3'd2;
   localparam logic [REG_AW-1:0] OFS_TEN  = 3'd4;
   localparam logic [REG_AW-1:0] OFS_CTL  = 3'd5;

   localparam logic [7:0] LOCK_BITS = 8'h03;
   localparam logic [7:0] CTL_ON    = 8'h01;
   localparam logic [7:0] CTL_RDREQ = 8'h02;
   localparam logic [7:0] CTL_WBUSY = 8'h04;
   localparam logic [7:0] TEN_ON    = 8'h01;

   // micro-step numbers of one entry
   localparam logic [3:0] STEP_EN_POLL  = 4'd2;
   localparam logic [3:0] STEP_FIX      = 4'd3;
   localparam logic [3:0] STEP_CLOSE    = 4'd11;
   localparam logic [3:0] STEP_LAST     = 4'd13;

   localparam int PAIR_W = 16;
   localparam int DEF_ENTRIES = 9;
   localparam logic [PAIR_W*DEF_ENTRIES-1:0] DEFAULT_TABLE = {
      16'h3001, 16'h7000, 16'h0711,
      16'h3001, 16'h700C, 16'h0705,
      16'h3001, 16'h7001, 16'h0706};

   typedef enum logic [1:0] {OP_RMW, OP_WR, OP_POLL} op_kind_e;

   typedef struct packed {
      op_kind_e          kind;
      logic [REG_AW-1:0] ofs;
      logic [7:0]        setm;   // set mask, write value or poll mask
      logic [7:0]        clrm;   // clear mask for read-modify-write
   } uop_t;

   typedef enum logic [3:0] {
      ST_BOOT, ST_ENTRY, ST_ISSUE, ST_FETCH, ST_STORE,
      ST_WAIT, ST_SAMPLE, ST_JUDGE, ST_HALT
   } seq_state_e;

   function automatic uop_t mk(op_kind_e k, logic [REG_AW-1:0] o,
                               logic [7:0] s, logic [7:0] c);
      uop_t u;
      u.kind = k;
      u.ofs  = o;
      u.setm = s;
      u.clrm = c;
      return u;
   endfunction

   function automatic uop_t uop_at(logic [3:0] step, logic [7:0] idx, logic [7:0] val);
      case (step)
         4'd0:    return mk(OP_RMW,  OFS_LOCK, LOCK_BITS, 8'h00);
         4'd1:    return mk(OP_RMW,  OFS_CTL,  CTL_ON,    8'h00);
         4'd2:    return mk(OP_POLL, OFS_CTL,  CTL_RDREQ | CTL_WBUSY, 8'h00);
         4'd3:    return mk(OP_RMW,  OFS_CTL,  8'h00,     CTL_RDREQ);
         4'd4:    return mk(OP_RMW,  OFS_TEN,  TEN_ON,    8'h00);
         4'd5:    return mk(OP_WR,   OFS_PTR,  8'h00,     8'h00);
         4'd6:    return mk(OP_WR,   OFS_DAT,  idx,       8'h00);
         4'd7:    return mk(OP_POLL, OFS_CTL,  CTL_WBUSY, 8'h00);
         4'd8:    return mk(OP_WR,   OFS_PTR,  8'h01,     8'h00);
         4'd9:    return mk(OP_WR,   OFS_DAT,  val,       8'h00);
         4'd10:   return mk(OP_POLL, OFS_CTL,  CTL_WBUSY, 8'h00);
         4'd11:   return mk(OP_RMW,  OFS_TEN,  8'h00,     TEN_ON);
         4'd12:   return mk(OP_RMW,  OFS_CTL,  8'h00,     CTL_ON);
         default: return mk(OP_RMW,  OFS_LOCK, 8'h00,     LOCK_BITS);
      endcase
   endfunction

endpackage

// File: rtl/cfgseq_table.sv
module cfgseq_table
   import cfgseq_pkg::*;
#(
   parameter int N_ENTRIES = 9,
   parameter logic [PAIR_W*N_ENTRIES-1:0] ENTRY_TABLE = '0,
   parameter int IW = 4
)(
   input  logic [IW-1:0] sel_i,
   output logic [7:0]    idx_o,
   output logic [7:0]    val_o
);

   logic [7:0] idx_a [N_ENTRIES];
   logic [7:0] val_a [N_ENTRIES];

   for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      assign idx_a[g] = ENTRY_TABLE[PAIR_W*g+8 +: 8];
      assign val_a[g] = ENTRY_TABLE[PAIR_W*g   +: 8];
   end

   always_comb begin
      idx_o = '0;
      val_o = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (sel_i == IW'(i)) begin
            idx_o = idx_a[i];
            val_o = val_a[i];
         end
      end
   end

endmodule

// File: rtl/cfgseq_poll.sv
module cfgseq_poll #(
   parameter int GAP   = 15,
   parameter int LIMIT = 10
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic again_i,
   input  logic waiting_i,
   output logic due_o,
   output logic last_o
);

   localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (GAP < 1) begin : g_bad_gap
      $error("cfgseq_poll: GAP must be at least 1");
   end
   if (LIMIT < 1) begin : g_bad_limit
      $error("cfgseq_poll: LIMIT must be at least 1");
   end

   logic [TW-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tries_q <= '0;
      else if (start_i) tries_q <= '0;
      else if (again_i) tries_q <= tries_q + TW'(1);
   end

   assign last_o = (tries_q == TW'(LIMIT-1));

   if (GAP > 1) begin : g_gap_cnt
      localparam int GW = $clog2(GAP);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   gap_q <= '0;
         else if (start_i || again_i)  gap_q <= '0;
         else if (waiting_i && !due_o) gap_q <= gap_q + GW'(1);
      end
      assign due_o = waiting_i && (gap_q == GW'(GAP-1));
   end else begin : g_gap_none
      assign due_o = waiting_i;
   end

   // R5
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= TW'(LIMIT-1));

   // R5
   no_retry_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      again_i |-> !last_o);

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
   import cfgseq_pkg::*;
#(
   parameter int N_ENTRIES = 9,
   parameter int IW = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_pwr_ok,
   input  logic [7:0]        ent_idx_i,
   input  logic [7:0]        ent_val_i,
   output logic [IW-1:0]     ent_sel_o,
   input  logic [7:0]        rdata_i,
   input  logic              due_i,
   input  logic              last_i,
   output logic              poll_start_o,
   output logic              poll_again_o,
   output logic              poll_wait_o,
   output logic              bus_vld_o,
   output logic              bus_wr_o,
   output logic [REG_AW-1:0] bus_addr_o,
   output logic [7:0]        bus_wdata_o,
   output logic              done_o,
   output logic              err_o,
   output logic [IW-1:0]     fail_idx_o
);

   seq_state_e    st_q;
   logic [3:0]    step_q;
   logic [IW-1:0] ent_q;
   logic [7:0]    cap_q;
   logic          bad_q;
   logic          done_q;
   logic          err_q;
   logic [IW-1:0] fail_q;
   uop_t          uop;
   logic          busy;

   assign uop       = uop_at(step_q, ent_idx_i, ent_val_i);
   assign busy      = |(cap_q & uop.setm);
   assign ent_sel_o = ent_q;

   assign poll_start_o = (st_q == ST_ISSUE) && (uop.kind == OP_POLL);
   assign poll_again_o = (st_q == ST_JUDGE) && busy && !last_i;
   assign poll_wait_o  = (st_q == ST_WAIT);

   always_comb begin
      bus_vld_o   = 1'b0;
      bus_wr_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      case (st_q)
         ST_FETCH: begin
            bus_vld_o  = 1'b1;
            bus_addr_o = uop.ofs;
         end
         ST_STORE: begin
            bus_vld_o   = 1'b1;
            bus_wr_o    = 1'b1;
            bus_addr_o  = uop.ofs;
            bus_wdata_o = (uop.kind == OP_RMW) ? ((cap_q | uop.setm) & ~uop.clrm)
                                               : uop.setm;
         end
         ST_SAMPLE: begin
            bus_vld_o  = 1'b1;
            bus_addr_o = OFS_CTL;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BOOT;
         step_q <= '0;
         ent_q  <= '0;
         cap_q  <= '0;
         bad_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         fail_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_BOOT: st_q <= ST_ENTRY;
            ST_ENTRY: begin
               if (bad_q) begin
                  err_q  <= 1'b1;
                  fail_q <= ent_q;
                  done_q <= 1'b1;
                  st_q   <= ST_HALT;
               end else if (ent_q == IW'(N_ENTRIES)) begin
                  done_q <= 1'b1;
                  st_q   <= ST_HALT;
               end else if (!host_pwr_ok) begin
                  err_q  <= 1'b1;
                  fail_q <= ent_q;
                  done_q <= 1'b1;
                  st_q   <= ST_HALT;
               end else begin
                  step_q <= '0;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               case (uop.kind)
                  OP_RMW:  st_q <= ST_FETCH;
                  OP_WR:   st_q <= ST_STORE;
                  default: st_q <= ST_WAIT;
               endcase
            end
            ST_FETCH: begin
               cap_q <= rdata_i;
               st_q  <= ST_STORE;
            end
            ST_STORE: begin
               if (step_q == STEP_LAST) begin
                  if (!bad_q) ent_q <= ent_q + IW'(1);
                  st_q <= ST_ENTRY;
               end else begin
                  step_q <= step_q + 4'd1;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_WAIT: if (due_i) st_q <= ST_SAMPLE;
            ST_SAMPLE: begin
               cap_q <= rdata_i;
               st_q  <= ST_JUDGE;
            end
            ST_JUDGE: begin
               if (!busy) begin
                  step_q <= (step_q == STEP_EN_POLL) ? STEP_FIX + 4'd1 : step_q + 4'd1;
                  st_q   <= ST_ISSUE;
               end else if (!last_i) begin
                  st_q <= ST_WAIT;
               end else if (step_q == STEP_EN_POLL) begin
                  step_q <= STEP_FIX;
                  st_q   <= ST_ISSUE;
               end else begin
                  bad_q  <= 1'b1;
                  step_q <= STEP_CLOSE;
                  st_q   <= ST_ISSUE;
               end
            end
            default: st_q <= ST_HALT;
         endcase
      end
   end

   assign done_o     = done_q;
   assign err_o      = err_q;
   assign fail_idx_o = fail_q;

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT) |-> !bus_vld_o);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R10
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HALT && $past(st_q) == ST_HALT) |-> $stable(fail_idx_o));

   // R7
   pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ENTRY && !bad_q && ent_q != IW'(N_ENTRIES) && !host_pwr_ok)
      |=> (err_o && done_o && !bus_vld_o));

endmodule

// File: rtl/cfgseq_init.sv
module cfgseq_init
   import cfgseq_pkg::*;
#(
   parameter int N_ENTRIES  = DEF_ENTRIES,
   parameter logic [PAIR_W*N_ENTRIES-1:0] ENTRY_TABLE = DEFAULT_TABLE,
   parameter int POLL_GAP   = 15,
   parameter int POLL_LIMIT = 10
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           host_pwr_ok,
   output logic                           bus_vld,
   output logic                           bus_wr,
   output logic [REG_AW-1:0]              bus_addr,
   output logic [7:0]                     bus_wdata,
   input  logic [7:0]                     bus_rdata,
   output logic                           done,
   output logic                           err,
   output logic [$clog2(N_ENTRIES+1)-1:0] fail_idx
);

   localparam int IW = $clog2(N_ENTRIES+1);

   if (N_ENTRIES < 1) begin : g_bad_entries
      $error("cfgseq_init: table needs at least one entry");
   end

   logic [IW-1:0] sel;
   logic [7:0]    idx_b;
   logic [7:0]    val_b;
   logic          p_start;
   logic          p_again;
   logic          p_wait;
   logic          p_due;
   logic          p_last;

   cfgseq_table #(
      .N_ENTRIES   (N_ENTRIES),
      .ENTRY_TABLE (ENTRY_TABLE),
      .IW          (IW)
   ) u_table (
      .sel_i (sel),
      .idx_o (idx_b),
      .val_o (val_b)
   );

   cfgseq_poll #(
      .GAP   (POLL_GAP),
      .LIMIT (POLL_LIMIT)
   ) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (p_start),
      .again_i   (p_again),
      .waiting_i (p_wait),
      .due_o     (p_due),
      .last_o    (p_last)
   );

   cfgseq_fsm #(
      .N_ENTRIES (N_ENTRIES),
      .IW        (IW)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_pwr_ok  (host_pwr_ok),
      .ent_idx_i    (idx_b),
      .ent_val_i    (val_b),
      .ent_sel_o    (sel),
      .rdata_i      (bus_rdata),
      .due_i        (p_due),
      .last_i       (p_last),
      .poll_start_o (p_start),
      .poll_again_o (p_again),
      .poll_wait_o  (p_wait),
      .bus_vld_o    (bus_vld),
      .bus_wr_o     (bus_wr),
      .bus_addr_o   (bus_addr),
      .bus_wdata_o  (bus_wdata),
      .done_o       (done),
      .err_o        (err),
      .fail_idx_o   (fail_idx)
   );

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!bus_vld && !done && !err));

endmodule

// File: tb/cfgseq_init_test.sv
module cfgseq_init_test;

   localparam int GAP   = 4;
   localparam int NENT  = 9;
   localparam int NSLOT = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_base = 1'b1;
   logic       pwr_ok;
   logic       bus_vld, bus_wr, done, err;
   logic [2:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic [3:0] fail_idx;

   always #4 clk = ~clk;   // 125 MHz

   cfgseq_init #(.POLL_GAP(GAP)) uut (
      .clk(clk), .rst_n(rst_n), .host_pwr_ok(pwr_ok),
      .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done(done), .err(err), .fail_idx(fail_idx));

   // bridge model
   logic [7:0] m_lock, m_ten, m_ptr, m_sel, m_ldn;
   logic [1:0] m_ctl;
   logic [7:0] m_irq [32];
   logic [7:0] m_act [32];
   int wbusy, dw_n, ul_n, ul_cyc, acc_n, done_n, done_cyc, viol, gap_hits, cyc, last_cyc;
   logic last_ctl_rd;
   int busy_for [NSLOT];
   int drop_at = -1;
   bit stuck = 1'b0;
   int errs = 0, checks = 0;

   assign pwr_ok = pwr_base && !(drop_at >= 0 && ul_n >= drop_at);

   always_comb begin
      case (bus_addr)
         3'd0:    bus_rdata = m_ptr;
         3'd2:    bus_rdata = m_lock;
         3'd4:    bus_rdata = m_ten;
         3'd5:    bus_rdata = {5'd0, (wbusy > 0), m_ctl};
         default: bus_rdata = 8'h00;
      endcase
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_lock <= 0; m_ten <= 0; m_ptr <= 0; m_sel <= 0; m_ldn <= 0;
         m_ctl <= {stuck, 1'b0};
         for (int i = 0; i < 32; i++) begin m_irq[i] <= 0; m_act[i] <= 0; end
         wbusy <= 0; dw_n <= 0; ul_n <= 0; ul_cyc <= 0; acc_n <= 0;
         done_n <= 0; done_cyc <= 0; viol <= 0; gap_hits <= 0; last_ctl_rd <= 0;
         last_cyc <= 0;
      end else begin
         if (done) begin done_n <= done_n + 1; done_cyc <= cyc; end
         if (bus_vld) begin
            acc_n <= acc_n + 1;
            last_cyc <= cyc;
            if (!bus_wr) begin
               if (bus_addr == 3'd5) begin
                  if (last_ctl_rd && (cyc - last_cyc) == GAP + 2) gap_hits <= gap_hits + 1;
                  if (wbusy > 0) wbusy <= wbusy - 1;
               end
               last_ctl_rd <= (bus_addr == 3'd5);
            end else begin
               last_ctl_rd <= 1'b0;
               case (bus_addr)
                  3'd0: m_ptr <= bus_wdata;
                  3'd1: begin
                     if (m_lock[1:0] != 2'b11 || !m_ten[0] || !m_ctl[0]) viol <= viol + 1;
                     if (m_ptr == 0) m_sel <= bus_wdata;
                     else begin
                        case (m_sel)
                           8'h07: m_ldn <= bus_wdata;
                           8'h70: m_irq[m_ldn[4:0]] <= bus_wdata;
                           8'h30: m_act[m_ldn[4:0]] <= bus_wdata;
                           default: ;
                        endcase
                     end
                     wbusy <= (dw_n < NSLOT) ? busy_for[dw_n] : 0;
                     dw_n <= dw_n + 1;
                  end
                  3'd2: begin
                     if (m_lock[1:0] != 0 && bus_wdata[1:0] == 0) begin
                        ul_n <= ul_n + 1; ul_cyc <= cyc;
                        if (m_ten[0] || m_ctl[0]) viol <= viol + 1;
                     end
                     m_lock <= bus_wdata;
                  end
                  3'd4: begin
                     if (m_ten[0] && !bus_wdata[0] && !m_ctl[0]) viol <= viol + 1;
                     if (!m_ten[0] && bus_wdata[0] && (m_lock[1:0] != 2'b11 || !m_ctl[0])) viol <= viol + 1;
                     m_ten <= bus_wdata;
                  end
                  3'd5: begin
                     if (m_ctl[0] && !bus_wdata[0] && m_ten[0]) viol <= viol + 1;
                     if (!m_ctl[0] && bus_wdata[0] && m_lock[1:0] != 2'b11) viol <= viol + 1;
                     m_ctl <= bus_wdata[1:0];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic logic [15:0] ref_pair(int e);
      case (e)
         0: return 16'h0706; 1: return 16'h7001; 2: return 16'h3001;
         3: return 16'h0705; 4: return 16'h700C; 5: return 16'h3001;
         6: return 16'h0711; 7: return 16'h7000; default: return 16'h3001;
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   int wd = 0;
   initial begin
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 190000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
         end
      end
   end

   task automatic run_case(string name, bit pwr, int drop, bit stk, int fslot);
      int n_full, exp_fail, exp_gap, slots, g;
      bit exp_err;
      logic [7:0] e_ldn;
      logic [7:0] e_irq [32];
      logic [7:0] e_act [32];
      int acc_snap;
      int devs [3];
      // expected result from the requirements
      exp_err = 1'b0; exp_fail = 0; n_full = NENT; slots = 2*NENT;
      if (!pwr) begin exp_err = 1; exp_fail = 0; n_full = 0; slots = 0; end
      else if (fslot >= 0 && fslot < NSLOT && (drop < 0 || fslot/2 < drop)) begin
         exp_err = 1; exp_fail = fslot/2; n_full = fslot/2 + fslot%2; slots = fslot + 1;
      end else if (drop >= 0 && drop < NENT) begin
         exp_err = 1; exp_fail = drop; n_full = drop; slots = 2*drop;
      end
      exp_gap = stk ? 9 : 0;
      for (int s = 0; s < slots; s++) exp_gap += (busy_for[s] > 9) ? 9 : busy_for[s];
      e_ldn = 0;
      for (int i = 0; i < 32; i++) begin e_irq[i] = 0; e_act[i] = 0; end
      for (int e = 0; e < n_full; e++) begin
         logic [15:0] p;
         p = ref_pair(e);
         if (p[15:8] == 8'h07) e_ldn = p[7:0];
         else if (p[15:8] == 8'h70) e_irq[e_ldn[4:0]] = p[7:0];
         else e_act[e_ldn[4:0]] = p[7:0];
      end

      pwr_base = pwr; drop_at = drop; stuck = stk;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R11
      chk(!done && !err && fail_idx == 0 && !bus_vld, "R11", {name, " reset state"},
          {done, err, bus_vld, fail_idx}, 0);
      rst_n = 1'b1;
      g = 0;
      while (done_n == 0 && g < 20000) begin @(negedge clk); g++; end
      chk(done_n > 0, "R9", {name, " walk finished"}, g, 0);
      repeat (20) @(negedge clk);
      acc_snap = acc_n;
      repeat (10) @(negedge clk);
      // R9
      chk(done_n == 1, "R9", {name, " done pulse count"}, done_n, 1);
      chk(acc_n == acc_snap, "R9", {name, " no access after done"}, acc_n, acc_snap);
      if (ul_n > 0)
         chk(done_cyc - ul_cyc == 2, "R9", {name, " done delay after unlock"}, done_cyc - ul_cyc, 2);
      // R10 R8
      chk(err == exp_err, "R10", {name, " err"}, err, exp_err);
      chk(fail_idx == exp_fail[3:0], "R8", {name, " fail_idx"}, fail_idx, exp_fail);
      if (!pwr) chk(acc_n == 0, "R7", {name, " no access without power"}, acc_n, 0);
      // R1 R2
      chk(m_ldn == e_ldn, "R1", {name, " selected device"}, m_ldn, e_ldn);
      devs[0] = 6; devs[1] = 5; devs[2] = 17;
      foreach (devs[k]) begin
         chk(m_irq[devs[k]] == e_irq[devs[k]] && m_act[devs[k]] == e_act[devs[k]],
             "R1", {name, " device image irq/act"},
             {m_irq[devs[k]], m_act[devs[k]]}, {e_irq[devs[k]], e_act[devs[k]]});
      end
      // R3 R6
      chk(viol == 0, "R3", {name, " bracket order violations"}, viol, 0);
      chk(m_lock[1:0] == 0 && m_ten[0] == 0 && m_ctl[0] == 0, "R6", {name, " bracket closed"},
          {m_lock[1:0], m_ten[0], m_ctl[0]}, 0);
      // R5
      chk(gap_hits == exp_gap, "R5", {name, " poll interval count"}, gap_hits, exp_gap);
      if (stk) chk(m_ctl[1] == 0, "R4", {name, " read request cleared"}, m_ctl[1], 0);
   endtask

   task automatic clear_busy();
      for (int s = 0; s < NSLOT; s++) busy_for[s] = 0;
   endtask

   initial begin
      void'($urandom(32'd7531));
      cyc = 0;
      clear_busy();
      run_case("clean", 1, -1, 0, -1);                       // R1 R3 R6
      run_case("no power", 0, -1, 0, -1);                    // R7
      run_case("power drop", 1, 4, 0, -1);                   // R7 R8
      run_case("enable stuck", 1, -1, 1, -1);                // R4
      clear_busy(); busy_for[17] = 9;
      run_case("busy nine", 1, -1, 0, -1);                   // R5 boundary pass
      clear_busy(); busy_for[17] = 10;
      run_case("busy ten data", 1, -1, 0, 17);               // R5 boundary fail
      clear_busy(); busy_for[0] = 10;
      run_case("busy ten first", 1, -1, 0, 0);               // R8
      for (int it = 0; it < 6; it++) begin
         int f;
         for (int s = 0; s < NSLOT; s++) busy_for[s] = $urandom % 10;
         f = $urandom % 24;
         if (f < NSLOT) busy_for[f] = 10; else f = -1;
         run_case($sformatf("random %0d", it), 1, -1, 0, f);
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule